// File: doc/BRIEF.md
# Test Access Port Controller with Two User Scan Hooks

This block is a serial test access port controller. It has a 16-state controller that steps on the rising edge of the test clock and a 3-bit instruction register. Eight opcodes choose which data register sits between the serial input and the serial output. Built-in registers are a one-bit bypass stage, a parameterised identification word and a boundary chain. Two opcodes hand the serial path to scan chains in user logic. For these the block gives a per-chain select, a gated data clock and a run-test indication. Two further opcodes pass a placeholder input straight to the serial output: one for readback and one for configuration.

The boundary chain is built from per-pin cells and has a fixed order. Two probe bits sit nearest the serial output. Each bidirectional pin adds three cells. Each input-only pin adds one cell. An update bit at the serial-input end drives an internal net through its latch. One opcode makes the latched cells drive the pads. The configuration opcode turns the pad outputs off. Every other opcode lets core logic drive the pads.

Top module: `jtag_tap_ctl`

## Requirements
- R1: Five consecutive rising test-clock edges with `tms` high reach Test-Logic-Reset from any state. While in that state the instruction register is loaded with opcode 110 (identification).
- R2: In Capture-IR the instruction shift stage loads 001. During Shift-IR, bit 0 comes out first. A new opcode takes effect at the Update-IR edge.
- R3: `tdo_o` and `tdo_oe` change only on the falling test-clock edge. `tdo_oe` is high only while the controller is in Shift-DR or Shift-IR, and `tdo_o` is 0 at all other times.
- R4: Opcode 111 selects a one-bit bypass stage that captures 0. Each bit on `tdi` appears on `tdo_o` one shift later.
- R5: Opcode 110 shifts out the `ID_VAL` parameter, least significant bit first.
- R6: Opcodes 000 and 001 select the boundary chain. Its capture layout, counted from the serial-output end, is: bit 0 is `probe_t`; bit 1 is `probe_o`; for bidirectional pin k, bit 2+3k is `pad_in[k]`, bit 3+3k is `core_out[k]` and bit 4+3k is `core_oe[k]`; for input-only pin j, bit 2+3·N_BIDIR+j is `pad_in_only[j]`; the last bit is the current update latch.
- R7: The boundary latches load from the chain only in Update-DR under opcode 000 or 001, and hold otherwise. `int_net` follows the last (serial-input end) latch.
- R8: Under opcode 000, `pad_out[k]` comes from latch 3+3k and `pad_oe[k]` from latch 4+3k. Under every opcode except 000 and 101, the pads follow `core_out` and `core_oe`.
- R9: Opcode 101 forces `pad_out` and `pad_oe` to 0 and routes `cfg_dout` to `tdo_o`. Opcode 100 routes `rdbk_din` to `tdo_o`.
- R10: Opcode 010 raises `usr_a_sel` and routes `usr_a_tdo` to `tdo_o`. Opcode 011 raises `usr_b_sel` and routes `usr_b_tdo`. The two selects are never high together.
- R11: `usr_drck` follows the test clock only while opcode 010 or 011 is active and the controller is in Capture-DR or Shift-DR. It is low otherwise. Its rising edges coincide with the test-clock edges in those states.
- R12: `usr_idle` is high exactly while the controller is in Run-Test/Idle.
- R13: A synchronous `rst` puts the controller in Test-Logic-Reset, sets the opcode to 110 and clears the boundary latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |
| tdo_oe | output | 1 | Serial output enable; pad is high impedance when low |
| usr_a_tdo | input | 1 | Serial return of user chain A |
| usr_b_tdo | input | 1 | Serial return of user chain B |
| rdbk_din | input | 1 | Placeholder readback serial data |
| cfg_dout | input | 1 | Placeholder configuration serial data |
| usr_a_sel | output | 1 | User chain A selected |
| usr_b_sel | output | 1 | User chain B selected |
| usr_drck | output | 1 | Gated data clock for user chains |
| usr_idle | output | 1 | Controller in Run-Test/Idle |
| probe_t | input | 1 | Internal probe captured into chain bit 0 |
| probe_o | input | 1 | Internal probe captured into chain bit 1 |
| pad_in | input | N_BIDIR | Pad input of each bidirectional pin |
| pad_in_only | input | N_INONLY | Input-only pins |
| core_out | input | N_BIDIR | Core output value per pin |
| core_oe | input | N_BIDIR | Core output enable per pin |
| pad_out | output | N_BIDIR | Value driven to each pad |
| pad_oe | output | N_BIDIR | Output enable of each pad |
| int_net | output | 1 | Internal net driven by the update-bit latch |

## Verification
The bench chases the off-by-one hazards. The first captured bit must be visible before any shift, the bypass delay must be exactly one stage, and a `tdo_o` driven from the rising edge would show a value half a cycle early. It checks the chain layout bit by bit, so a swapped out/enable cell or a misplaced input-only cell shows up as a wrong serial word and as wrong pad levels under the drive-from-latch opcode. It counts data-clock pulses during user scans and during built-in scans; a gate that is too wide, or one that ignores the opcode, changes that count. It asserts reset in the middle of a shift and also escapes a shift by holding `tms` high, then expects the identification word to come back in both cases.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  localparam int IR_W = 3;

  // Opcodes: the encoding is part of the external behaviour
  localparam logic [IR_W-1:0] OP_EXT   = 3'b000;
  localparam logic [IR_W-1:0] OP_SAMP  = 3'b001;
  localparam logic [IR_W-1:0] OP_USR_A = 3'b010;
  localparam logic [IR_W-1:0] OP_USR_B = 3'b011;
  localparam logic [IR_W-1:0] OP_RDBK  = 3'b100;
  localparam logic [IR_W-1:0] OP_CFG   = 3'b101;
  localparam logic [IR_W-1:0] OP_IDC   = 3'b110;
  localparam logic [IR_W-1:0] OP_BYP   = 3'b111;

  localparam logic [IR_W-1:0] IR_CAPTURE_VAL = 3'b001;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_st_e;

  function automatic tap_st_e tap_next(input tap_st_e s, input logic m);
    case (s)
      ST_TLR:    return m ? ST_TLR    : ST_RTI;
      ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
      default:   return m ? ST_SEL_DR : ST_RTI;
    endcase
  endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic    tck,
  input  logic    rst,
  input  logic    tms,
  output tap_st_e st
);

  always_ff @(posedge tck) begin
    if (rst) st <= ST_TLR;
    else     st <= tap_next(st, tms);
  end

endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
  import jtag_tap_pkg::*;
(
  input  logic            tck,
  input  logic            rst,
  input  logic            tdi,
  input  tap_st_e         st,
  output logic [IR_W-1:0] ir,
  output logic            so
);

  logic [IR_W-1:0] sr;

  always_ff @(posedge tck) begin
    if (rst) begin
      sr <= IR_CAPTURE_VAL;
      ir <= OP_IDC;
    end else begin
      case (st)
        ST_TLR:    ir <= OP_IDC;
        ST_CAP_IR: sr <= IR_CAPTURE_VAL;
        ST_SH_IR:  sr <= {tdi, sr[IR_W-1:1]};
        ST_UPD_IR: ir <= sr;
        default: ;
      endcase
    end
  end

  assign so = sr[0];

endmodule

// File: rtl/jtag_tap_bsr.sv
module jtag_tap_bsr #(
  parameter int N_BIDIR  = 4,
  parameter int N_INONLY = 2,
  localparam int BASE_IN = 2 + 3 * N_BIDIR,
  localparam int LEN     = BASE_IN + N_INONLY + 1
) (
  input  logic                tck,
  input  logic                rst,
  input  logic                en,
  input  logic                cap,
  input  logic                shf,
  input  logic                upd,
  input  logic                tdi,
  input  logic                probe_t,
  input  logic                probe_o,
  input  logic [N_BIDIR-1:0]  pad_in,
  input  logic [N_INONLY-1:0] pad_in_only,
  input  logic [N_BIDIR-1:0]  core_out,
  input  logic [N_BIDIR-1:0]  core_oe,
  output logic                so,
  output logic [N_BIDIR-1:0]  lat_out,
  output logic [N_BIDIR-1:0]  lat_oe,
  output logic                lat_net,
  output logic [LEN-1:0]      lat_vec
);

  logic [LEN-1:0] cap_v;
  logic [LEN-1:0] sr;
  logic [LEN-1:0] lat;

  // Capture layout: probes at the serial-out end, update bit at the serial-in end
  always_comb begin
    cap_v        = '0;
    cap_v[0]     = probe_t;
    cap_v[1]     = probe_o;
    for (int k = 0; k < N_BIDIR; k++) begin
      cap_v[2 + 3*k] = pad_in[k];
      cap_v[3 + 3*k] = core_out[k];
      cap_v[4 + 3*k] = core_oe[k];
    end
    for (int j = 0; j < N_INONLY; j++)
      cap_v[BASE_IN + j] = pad_in_only[j];
    cap_v[LEN-1] = lat[LEN-1];
  end

  always_ff @(posedge tck) begin
    if (rst) begin
      sr  <= '0;
      lat <= '0;
    end else if (en) begin
      if (cap)      sr  <= cap_v;
      else if (shf) sr  <= {tdi, sr[LEN-1:1]};
      if (upd)      lat <= sr;
    end
  end

  genvar k;
  generate
    for (k = 0; k < N_BIDIR; k++) begin : g_pin
      assign lat_out[k] = lat[3 + 3*k];
      assign lat_oe[k]  = lat[4 + 3*k];
    end
  endgenerate

  assign so      = sr[0];
  assign lat_net = lat[LEN-1];
  assign lat_vec = lat;

endmodule

// File: rtl/jtag_tap_ctl.sv
module jtag_tap_ctl
  import jtag_tap_pkg::*;
#(
  parameter int              N_BIDIR  = 4,
  parameter int              N_INONLY = 2,
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VAL   = 32'h1A5C_3093
) (
  input  logic                tck,
  input  logic                rst,
  input  logic                tms,
  input  logic                tdi,
  output logic                tdo_o,
  output logic                tdo_oe,
  input  logic                usr_a_tdo,
  input  logic                usr_b_tdo,
  input  logic                rdbk_din,
  input  logic                cfg_dout,
  output logic                usr_a_sel,
  output logic                usr_b_sel,
  output logic                usr_drck,
  output logic                usr_idle,
  input  logic                probe_t,
  input  logic                probe_o,
  input  logic [N_BIDIR-1:0]  pad_in,
  input  logic [N_INONLY-1:0] pad_in_only,
  input  logic [N_BIDIR-1:0]  core_out,
  input  logic [N_BIDIR-1:0]  core_oe,
  output logic [N_BIDIR-1:0]  pad_out,
  output logic [N_BIDIR-1:0]  pad_oe,
  output logic                int_net
);

  localparam int BS_LEN = 3 + 3 * N_BIDIR + N_INONLY;

  tap_st_e         st;
  logic [IR_W-1:0] ir;
  logic            ir_so;
  logic            bs_so;
  logic            bs_sel;
  logic            user_op;
  logic            dr_so;
  logic            byp_q;
  logic [ID_W-1:0] id_q;
  logic            drck_en;
  logic [N_BIDIR-1:0] lat_out;
  logic [N_BIDIR-1:0] lat_oe;
  logic [BS_LEN-1:0]  lat_vec;

  jtag_tap_fsm u_fsm (.tck(tck), .rst(rst), .tms(tms), .st(st));

  jtag_tap_ir u_ir (.tck(tck), .rst(rst), .tdi(tdi), .st(st), .ir(ir), .so(ir_so));

  assign bs_sel  = (ir == OP_EXT) || (ir == OP_SAMP);
  assign user_op = (ir == OP_USR_A) || (ir == OP_USR_B);

  jtag_tap_bsr #(.N_BIDIR(N_BIDIR), .N_INONLY(N_INONLY)) u_bsr (
    .tck(tck), .rst(rst), .en(bs_sel),
    .cap(st == ST_CAP_DR), .shf(st == ST_SH_DR), .upd(st == ST_UPD_DR),
    .tdi(tdi), .probe_t(probe_t), .probe_o(probe_o),
    .pad_in(pad_in), .pad_in_only(pad_in_only),
    .core_out(core_out), .core_oe(core_oe),
    .so(bs_so), .lat_out(lat_out), .lat_oe(lat_oe),
    .lat_net(int_net), .lat_vec(lat_vec)
  );

  // Bypass stage and identification register
  always_ff @(posedge tck) begin
    if (rst) begin
      byp_q <= 1'b0;
      id_q  <= ID_VAL;
    end else if (st == ST_CAP_DR) begin
      byp_q <= 1'b0;
      id_q  <= ID_VAL;
    end else if (st == ST_SH_DR) begin
      byp_q <= tdi;
      id_q  <= {tdi, id_q[ID_W-1:1]};
    end
  end

  always_comb begin
    case (ir)
      OP_EXT, OP_SAMP: dr_so = bs_so;
      OP_USR_A:        dr_so = usr_a_tdo;
      OP_USR_B:        dr_so = usr_b_tdo;
      OP_RDBK:         dr_so = rdbk_din;
      OP_CFG:          dr_so = cfg_dout;
      OP_IDC:          dr_so = id_q[0];
      default:         dr_so = byp_q;
    endcase
  end

  // Falling-edge output stage and user clock gate
  always_ff @(negedge tck) begin
    if (rst) begin
      tdo_o   <= 1'b0;
      tdo_oe  <= 1'b0;
      drck_en <= 1'b0;
    end else begin
      tdo_oe  <= (st == ST_SH_DR) || (st == ST_SH_IR);
      tdo_o   <= (st == ST_SH_IR) ? ir_so : ((st == ST_SH_DR) ? dr_so : 1'b0);
      drck_en <= user_op && ((st == ST_CAP_DR) || (st == ST_SH_DR));
    end
  end

  assign usr_drck  = tck & drck_en;
  assign usr_a_sel = (ir == OP_USR_A);
  assign usr_b_sel = (ir == OP_USR_B);
  assign usr_idle  = (st == ST_RTI);

  assign pad_out = (ir == OP_EXT) ? lat_out : ((ir == OP_CFG) ? '0 : core_out);
  assign pad_oe  = (ir == OP_EXT) ? lat_oe  : ((ir == OP_CFG) ? '0 : core_oe);

endmodule

// File: rtl/jtag_tap_ctl_chk.sv
module jtag_tap_ctl_chk
  import jtag_tap_pkg::*;
#(
  parameter int N_BIDIR = 4,
  parameter int LAT_W   = 17
) (
  input logic               tck,
  input logic               rst,
  input logic               tms,
  input tap_st_e            st,
  input logic [IR_W-1:0]    ir,
  input logic               tdo_oe,
  input logic               usr_a_sel,
  input logic               usr_b_sel,
  input logic               usr_idle,
  input logic               drck_en,
  input logic [N_BIDIR-1:0] pad_oe,
  input logic [LAT_W-1:0]   lat_vec
);

  p_five_ones_r1: assert property (@(posedge tck) disable iff (rst)
    ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
      |-> (st == ST_TLR));

  p_reset_opcode_r1: assert property (@(posedge tck) disable iff (rst)
    (st == ST_TLR) |=> (ir == OP_IDC));

  p_oe_in_shift_r3: assert property (@(posedge tck) disable iff (rst)
    tdo_oe == ((st == ST_SH_DR) || (st == ST_SH_IR)));

  p_latch_hold_r7: assert property (@(posedge tck) disable iff (rst)
    !((st == ST_UPD_DR) && ((ir == OP_EXT) || (ir == OP_SAMP))) |=> $stable(lat_vec));

  p_cfg_pads_off_r9: assert property (@(posedge tck) disable iff (rst)
    (ir == OP_CFG) |-> (pad_oe == '0));

  p_sel_exclusive_r10: assert property (@(posedge tck) disable iff (rst)
    $onehot0({usr_a_sel, usr_b_sel}));

  p_drck_window_r11: assert property (@(posedge tck) disable iff (rst)
    drck_en |-> (((ir == OP_USR_A) || (ir == OP_USR_B)) && ((st == ST_CAP_DR) || (st == ST_SH_DR))));

  p_idle_state_r12: assert property (@(posedge tck) disable iff (rst)
    usr_idle == (st == ST_RTI));

endmodule

bind jtag_tap_ctl jtag_tap_ctl_chk #(.N_BIDIR(N_BIDIR), .LAT_W(BS_LEN)) u_chk (
  .tck(tck), .rst(rst), .tms(tms), .st(st), .ir(ir), .tdo_oe(tdo_oe),
  .usr_a_sel(usr_a_sel), .usr_b_sel(usr_b_sel), .usr_idle(usr_idle),
  .drck_en(drck_en), .pad_oe(pad_oe), .lat_vec(lat_vec)
);

// File: tb/jtag_tap_ctl_bench.sv
module jtag_tap_ctl_bench;

  localparam int NB = 4;
  localparam int NI = 2;
  localparam int L  = 3 + 3 * NB + NI;
  localparam logic [31:0] ID = 32'h1A5C_3093;

  // behavioural state numbering
  localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_SHD = 4, S_E1D = 5,
                 S_PD = 6, S_E2D = 7, S_UDR = 8, S_SIR = 9, S_CIR = 10, S_SHI = 11,
                 S_E1I = 12, S_PI = 13, S_E2I = 14, S_UIR = 15;

  logic tck = 1'b0;
  logic rst = 1'b1, tms = 1'b1, tdi = 1'b0;
  logic usr_a_tdo = 1'b0, usr_b_tdo = 1'b0, rdbk_din = 1'b0, cfg_dout = 1'b0;
  logic probe_t = 1'b0, probe_o = 1'b0;
  logic [NB-1:0] pad_in = '0, core_out = '0, core_oe = '0;
  logic [NI-1:0] pad_in_only = '0;
  logic tdo_o, tdo_oe, usr_a_sel, usr_b_sel, usr_drck, usr_idle, int_net;
  logic [NB-1:0] pad_out, pad_oe;

  int n_tests = 0, n_fail = 0, drck_cnt = 0;
  bit chk_on = 1'b0;

  always #10 tck = ~tck;

  jtag_tap_ctl #(.N_BIDIR(NB), .N_INONLY(NI), .ID_W(32), .ID_VAL(ID)) u_jtag_tap_ctl (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo_o(tdo_o), .tdo_oe(tdo_oe),
    .usr_a_tdo(usr_a_tdo), .usr_b_tdo(usr_b_tdo), .rdbk_din(rdbk_din), .cfg_dout(cfg_dout),
    .usr_a_sel(usr_a_sel), .usr_b_sel(usr_b_sel), .usr_drck(usr_drck), .usr_idle(usr_idle),
    .probe_t(probe_t), .probe_o(probe_o), .pad_in(pad_in), .pad_in_only(pad_in_only),
    .core_out(core_out), .core_oe(core_oe), .pad_out(pad_out), .pad_oe(pad_oe),
    .int_net(int_net)
  );

  always @(posedge usr_drck) drck_cnt++;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_st = S_TLR;
  int m_ir = 6;
  bit m_lat[L];
  bit irq[$];
  bit dr_q[$];
  bit m_tdo = 1'b0, m_oe = 1'b0, m_gate = 1'b0;

  function automatic int nxt(input int s, input bit m);
    case (s)
      S_TLR: return m ? S_TLR : S_RTI;
      S_RTI: return m ? S_SDR : S_RTI;
      S_SDR: return m ? S_SIR : S_CDR;
      S_CDR: return m ? S_E1D : S_SHD;
      S_SHD: return m ? S_E1D : S_SHD;
      S_E1D: return m ? S_UDR : S_PD;
      S_PD:  return m ? S_E2D : S_PD;
      S_E2D: return m ? S_UDR : S_SHD;
      S_UDR: return m ? S_SDR : S_RTI;
      S_SIR: return m ? S_TLR : S_CIR;
      S_CIR: return m ? S_E1I : S_SHI;
      S_SHI: return m ? S_E1I : S_SHI;
      S_E1I: return m ? S_UIR : S_PI;
      S_PI:  return m ? S_E2I : S_PI;
      S_E2I: return m ? S_UIR : S_SHI;
      default: return m ? S_SDR : S_RTI;
    endcase
  endfunction

  // capture word of the boundary chain, as laid out in R6
  function automatic logic [L-1:0] bs_word();
    logic [L-1:0] w;
    w[0] = probe_t;
    w[1] = probe_o;
    for (int k = 0; k < NB; k++) begin
      w[2 + 3*k] = pad_in[k];
      w[3 + 3*k] = core_out[k];
      w[4 + 3*k] = core_oe[k];
    end
    for (int j = 0; j < NI; j++) w[2 + 3*NB + j] = pad_in_only[j];
    w[L-1] = m_lat[L-1];
    return w;
  endfunction

  always @(posedge tck) begin
    if (rst) begin
      m_st = S_TLR; m_ir = 6;
      for (int i = 0; i < L; i++) m_lat[i] = 1'b0;
      dr_q.delete();
    end else begin
      case (m_st)
        S_TLR: m_ir = 6;
        S_CIR: irq = '{1'b1, 1'b0, 1'b0};
        S_SHI: begin irq.push_back(tdi); void'(irq.pop_front()); end
        S_UIR: m_ir = int'(irq[0]) + 2 * int'(irq[1]) + 4 * int'(irq[2]);
        S_CDR: begin
          logic [L-1:0] w;
          dr_q.delete();
          if (m_ir <= 1) begin
            w = bs_word();
            for (int i = 0; i < L; i++) dr_q.push_back(w[i]);
          end else if (m_ir == 6) begin
            for (int i = 0; i < 32; i++) dr_q.push_back(ID[i]);
          end else if (m_ir == 7) dr_q.push_back(1'b0);
        end
        S_SHD: if (dr_q.size() > 0) begin dr_q.push_back(tdi); void'(dr_q.pop_front()); end
        S_UDR: if (m_ir <= 1) for (int i = 0; i < L; i++) m_lat[i] = dr_q[i];
        default: ;
      endcase
      m_st = nxt(m_st, tms);
    end
  end

  always @(negedge tck) begin
    if (rst) begin
      m_tdo = 1'b0; m_oe = 1'b0; m_gate = 1'b0;
    end else begin
      m_oe   = (m_st == S_SHD) || (m_st == S_SHI);
      m_gate = (m_ir == 2 || m_ir == 3) && (m_st == S_CDR || m_st == S_SHD);
      if (m_st == S_SHI) m_tdo = irq[0];
      else if (m_st == S_SHD) begin
        case (m_ir)
          2: m_tdo = usr_a_tdo;
          3: m_tdo = usr_b_tdo;
          4: m_tdo = rdbk_din;
          5: m_tdo = cfg_dout;
          default: m_tdo = dr_q[0];
        endcase
      end else m_tdo = 1'b0;
    end
  end

  function automatic string tdo_tag();
    if (!m_oe) return "R3 tdo idle";
    if (m_st == S_SHI || m_st == S_E1I) return "R2 ir shift";
    case (m_ir)
      0, 1: return "R6 boundary";
      2, 3: return "R10 user";
      4, 5: return "R9 placeholder";
      6: return "R5 idcode";
      default: return "R4 bypass";
    endcase
  endfunction

  // cycle-by-cycle comparison, away from the edges
  always @(posedge tck) begin
    #5;
    if (chk_on) begin
      logic [NB-1:0] e_out, e_oe;
      for (int k = 0; k < NB; k++) begin
        e_out[k] = (m_ir == 0) ? m_lat[3 + 3*k] : ((m_ir == 5) ? 1'b0 : core_out[k]);
        e_oe[k]  = (m_ir == 0) ? m_lat[4 + 3*k] : ((m_ir == 5) ? 1'b0 : core_oe[k]);
      end
      chk(tdo_tag(), tdo_o, m_tdo);
      chk("R3 tdo_oe", tdo_oe, m_oe);
      chk("R12 idle", usr_idle, m_st == S_RTI);
      chk("R10 selects", {usr_a_sel, usr_b_sel}, {m_ir == 2, m_ir == 3});
      chk("R11 drck high phase", usr_drck, m_gate);
      chk((m_ir == 5) ? "R9 pads" : "R8 pads", {pad_out, pad_oe}, {e_out, e_oe});
      chk("R7 int_net", int_net, m_lat[L-1]);
      #10;
      chk("R11 drck low phase", usr_drck, 1'b0);
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input bit m, input bit d);
    tms = m; tdi = d;
    @(posedge tck);
    #15;
  endtask

  task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo_o;
      step(i == n - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo_o;
      step(i == 2, op[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL R1..: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] o;
    logic [2:0]  c;
    logic [L-1:0] p, q, w;
    int d0;

    repeat (3) @(posedge tck);
    #15;
    rst = 1'b0;
    chk_on = 1'b1;
    chk("R13 reset tdo_oe", tdo_oe, 1'b0);
    chk("R13 reset idle", usr_idle, 1'b0);

    step(0, 0);
    chk("R12 idle in run-test", usr_idle, 1'b1);

    shift_dr(32, 64'h0, o);
    chk("R5 R1 default idcode", o[31:0], ID);

    load_ir(3'b111, c);
    chk("R2 ir capture pattern", c, 3'b001);

    shift_dr(8, 64'hB2, o);
    chk("R4 bypass first bit", o[0], 1'b0);
    chk("R4 bypass delay", o[7:1], 7'h32);

    // boundary sample
    pad_in = 4'b1100; core_out = 4'b1010; core_oe = 4'b0110;
    pad_in_only = 2'b01; probe_t = 1'b1; probe_o = 1'b0;
    load_ir(3'b001, c);
    w = bs_word();
    p = 17'h1B2D5;
    shift_dr(L, 64'(p), o);
    chk("R6 capture layout", o[L-1:0], w);
    chk("R7 update bit drives net", int_net, p[L-1]);
    chk("R8 sample keeps core", {pad_out, pad_oe}, {core_out, core_oe});

    load_ir(3'b000, c);
    for (int k = 0; k < NB; k++) begin
      chk("R8 extest pad_out", pad_out[k], p[3 + 3*k]);
      chk("R8 extest pad_oe", pad_oe[k], p[4 + 3*k]);
    end
    q = 17'h0A6E3;
    shift_dr(L, 64'(q), o);
    chk("R7 new latch net", int_net, q[L-1]);

    load_ir(3'b111, c);
    shift_dr(5, 64'h1F, o);
    chk("R7 hold under bypass", int_net, q[L-1]);
    load_ir(3'b000, c);
    for (int k = 0; k < NB; k++)
      chk("R7 R8 latches held", {pad_out[k], pad_oe[k]}, {q[3 + 3*k], q[4 + 3*k]});

    // user chains
    usr_a_tdo = 1'b1; usr_b_tdo = 1'b0;
    load_ir(3'b010, c);
    chk("R10 user A selects", {usr_a_sel, usr_b_sel}, 2'b10);
    d0 = drck_cnt;
    shift_dr(6, 64'h0, o);
    chk("R10 user A data", o[5:0], 6'h3F);
    chk("R11 drck pulses user A", drck_cnt - d0, 7);
    load_ir(3'b011, c);
    chk("R10 user B selects", {usr_a_sel, usr_b_sel}, 2'b01);
    shift_dr(4, 64'h0, o);
    chk("R10 user B data", o[3:0], 4'h0);
    load_ir(3'b111, c);
    d0 = drck_cnt;
    shift_dr(4, 64'h0, o);
    chk("R11 no drck in bypass", drck_cnt - d0, 0);

    // placeholder routes
    cfg_dout = 1'b1; rdbk_din = 1'b0;
    load_ir(3'b101, c);
    chk("R9 config pads off", {pad_out, pad_oe}, '0);
    shift_dr(4, 64'h0, o);
    chk("R9 config data", o[3:0], 4'hF);
    cfg_dout = 1'b0; rdbk_din = 1'b1;
    load_ir(3'b100, c);
    shift_dr(4, 64'h0, o);
    chk("R9 readback data", o[3:0], 4'hF);
    chk("R8 readback keeps core", {pad_out, pad_oe}, {core_out, core_oe});

    // escape from Shift-DR with five ones
    load_ir(3'b111, c);
    step(1, 0); step(0, 0); step(0, 0);
    chk("R12 idle low in shift", usr_idle, 1'b0);
    repeat (5) step(1, 0);
    step(0, 0);
    shift_dr(32, 64'h0, o);
    chk("R1 five ones restore idcode", o[31:0], ID);

    // synchronous reset in the middle of a shift
    load_ir(3'b000, c);
    step(1, 0); step(0, 0); step(0, 1); step(0, 1);
    rst = 1'b1;
    step(0, 0);
    rst = 1'b0;
    #10;
    chk("R13 reset clears tdo_oe", tdo_oe, 1'b0);
    chk("R13 reset clears latch", int_net, 1'b0);
    step(0, 0);
    shift_dr(32, 64'h0, o);
    chk("R13 reset opcode idcode", o[31:0], ID);

    repeat (2) step(0, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule